// File: doc/BRIEF.md
# Bus Mastership Arbiter

This block decides who drives a local bus: the processor core or one of several external masters. It takes a single hold-style request and a set of request channels. The channels are ranked by fixed priority, and the lowest index wins. A parameter sets whether the hold request ranks above or below the channels. When any request appears, the arbiter tells the core to stop starting new bus cycles. It hands the bus over only when the core reports the end of a bus cycle and no locked instruction is running. Hold requests are answered on an active-high acknowledge. Channel requests are answered on a one-hot grant vector.

A grant lasts as long as its requester keeps asking. When the requester drops its request, or pulses its release line, the bus returns to the core on the next clock. Any other pending request must then wait for a fresh cycle boundary. The reset input takes effect only after it has been high for a set number of consecutive clock edges. Shorter pulses are ignored.

Top module: `bus_master_arbiter`

## Requirements
- R1: When `rst_i` has been sampled high on RST_CYCLES consecutive rising edges (default 4), the block returns to core ownership on that edge, with all grants, `hold_ack_o` and `core_hold_o` low. A shorter high pulse leaves the state unchanged.
- R2: A request seen while the core owns the bus raises `core_hold_o` after the next edge, with no grant yet. `core_hold_o` stays high for the whole time a grant or acknowledge is active.
- R3: A grant or acknowledge rises only on an edge where `cyc_end_i` is sampled high.
- R4: While `lock_n_i` is low, no grant or acknowledge is issued. A request made during that time stays pending and is served at the first edge where `cyc_end_i` is high and `lock_n_i` is high.
- R5: When several requests are active at a grant edge, channel 0 beats channel 1. With HOLD_FIRST=0 (the default), any channel beats the hold request.
- R6: A channel grant stays active while its request bit is high. If the request drops, or that channel's `rel_i` bit is high at an edge, all grants and `core_hold_o` go low after that edge.
- R7: After a release, a waiting request is granted no earlier than two edges later. The core always gets one owned cycle and then a new boundary.
- R8: At most one of `hold_ack_o` and the bits of `gnt_o` is high at any time. Bit i of `gnt_o` belongs to channel i.
- R9: `hold_ack_o` rises only for a sampled `hold_req_i` and falls one edge after `hold_req_i` is sampled low. A request withdrawn before its boundary returns the bus to the core with no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Reset, active high, qualified over RST_CYCLES edges |
| hold_req_i | input | 1 | Hold-style bus request |
| hold_ack_o | output | 1 | Hold acknowledge, active high |
| req_i | input | NCH | Per-channel bus request, index 0 highest priority |
| rel_i | input | NCH | Per-channel release pulse |
| gnt_o | output | NCH | One-hot per-channel grant |
| cyc_end_i | input | 1 | Core is at a bus-cycle boundary this cycle |
| lock_n_i | input | 1 | Active-low locked-instruction indication from the core |
| core_hold_o | output | 1 | Tells the core to start no new bus cycle |

## Verification
Two pairs of events can fall on the same edge.

- **Lock clearing and a boundary.** `lock_n_i` rises in the same cycle that `cyc_end_i` is high, with requests already pending. The grant must appear on exactly that edge, not one later.
- **A release and a competing request.** The owner of a grant releases while a lower-priority channel is still asserting. The loser must pass through a core-owned cycle before it can be granted.

Directed sequences set up both overlaps. A long random phase then drives every input at once, including reset pulses of random length. On every clock, each output is compared with a behavioural reference model.

// File: rtl/arb_pkg.sv
package arb_pkg;

   // Ownership phase of the local bus
   typedef enum logic [1:0] {
      CORE_OWNS     = 2'd0,
      WAIT_BOUNDARY = 2'd1,
      GRANTED_HOLD  = 2'd2,
      GRANTED_CH    = 2'd3
   } own_phase_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/arb_rst_qual.sv
module arb_rst_qual #(
   parameter int RST_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_i,
   output logic qual_rst_o
);
   localparam int CW = $clog2(RST_CYCLES + 1);
   localparam logic [CW-1:0] LIMIT = CW'(RST_CYCLES - 1);

   generate
      if (RST_CYCLES < 1) begin : g_bad_rst
         $error("RST_CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_i)
         run_q <= '0;
      else if (run_q < LIMIT)
         run_q <= run_q + 1'b1;
   end

   assign qual_rst_o = rst_i && (run_q >= LIMIT);

   // R1
   qual_needs_rst_chk: assert property (@(posedge clk) qual_rst_o |-> rst_i && ((RST_CYCLES < 2) || $past(rst_i)));

endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
   parameter int NCH        = 2,
   parameter bit HOLD_FIRST = 1'b0,
   localparam int IW        = arb_pkg::idx_width(NCH)
) (
   input  logic [NCH-1:0] req_i,
   input  logic           hold_req_i,
   output logic           any_o,
   output logic           pick_hold_o,
   output logic [IW-1:0]  pick_idx_o
);
   logic          ch_any;
   logic [IW-1:0] ch_idx;

   always_comb begin
      ch_idx = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (req_i[i]) ch_idx = IW'(i);
      end
   end

   assign ch_any = |req_i;
   assign any_o  = ch_any | hold_req_i;
   assign pick_idx_o = ch_idx;

   generate
      if (HOLD_FIRST) begin : g_hold_high
         assign pick_hold_o = hold_req_i;
      end else begin : g_hold_low
         assign pick_hold_o = hold_req_i && !ch_any;
      end
   endgenerate

endmodule

// File: rtl/arb_grant_dec.sv
module arb_grant_dec #(
   parameter int NCH = 2,
   localparam int IW = arb_pkg::idx_width(NCH)
) (
   input  arb_pkg::own_phase_e phase_i,
   input  logic [IW-1:0]       idx_i,
   output logic                hold_ack_o,
   output logic [NCH-1:0]      gnt_o,
   output logic                core_hold_o
);
   import arb_pkg::*;

   genvar g;
   generate
      for (g = 0; g < NCH; g++) begin : g_gnt
         assign gnt_o[g] = (phase_i == GRANTED_CH) && (idx_i == IW'(g));
      end
   endgenerate

   assign hold_ack_o  = (phase_i == GRANTED_HOLD);
   assign core_hold_o = (phase_i != CORE_OWNS);

endmodule

// File: rtl/bus_master_arbiter.sv
module bus_master_arbiter #(
   parameter int NCH        = 2,
   parameter int RST_CYCLES = 4,
   parameter bit HOLD_FIRST = 1'b0
) (
   input  logic           clk,
   input  logic           rst_i,
   input  logic           hold_req_i,
   output logic           hold_ack_o,
   input  logic [NCH-1:0] req_i,
   input  logic [NCH-1:0] rel_i,
   output logic [NCH-1:0] gnt_o,
   input  logic           cyc_end_i,
   input  logic           lock_n_i,
   output logic           core_hold_o
);
   import arb_pkg::*;

   localparam int IW = idx_width(NCH);

   generate
      if (NCH < 1) begin : g_bad_nch
         $error("NCH must be at least 1");
      end
   endgenerate

   logic          qual_rst;
   logic          any_req;
   logic          pick_hold;
   logic [IW-1:0] pick_idx;
   own_phase_e    phase_q, phase_d;
   logic [IW-1:0] idx_q, idx_d;

   arb_rst_qual #(.RST_CYCLES(RST_CYCLES)) u_rst (
      .clk       (clk),
      .rst_i     (rst_i),
      .qual_rst_o(qual_rst)
   );

   arb_pick #(.NCH(NCH), .HOLD_FIRST(HOLD_FIRST)) u_pick (
      .req_i      (req_i),
      .hold_req_i (hold_req_i),
      .any_o      (any_req),
      .pick_hold_o(pick_hold),
      .pick_idx_o (pick_idx)
   );

   always_comb begin
      phase_d = phase_q;
      idx_d   = idx_q;
      unique case (phase_q)
         CORE_OWNS: begin
            if (any_req) phase_d = WAIT_BOUNDARY;
         end
         WAIT_BOUNDARY: begin
            if (!any_req) begin
               phase_d = CORE_OWNS;
            end else if (cyc_end_i && lock_n_i) begin
               if (pick_hold) begin
                  phase_d = GRANTED_HOLD;
               end else begin
                  phase_d = GRANTED_CH;
                  idx_d   = pick_idx;
               end
            end
         end
         GRANTED_HOLD: begin
            if (!hold_req_i) phase_d = CORE_OWNS;
         end
         GRANTED_CH: begin
            if (!req_i[idx_q] || rel_i[idx_q]) phase_d = CORE_OWNS;
         end
         default: phase_d = CORE_OWNS;
      endcase
   end

   always_ff @(posedge clk) begin
      if (qual_rst) begin
         phase_q <= CORE_OWNS;
         idx_q   <= '0;
      end else begin
         phase_q <= phase_d;
         idx_q   <= idx_d;
      end
   end

   arb_grant_dec #(.NCH(NCH)) u_dec (
      .phase_i    (phase_q),
      .idx_i      (idx_q),
      .hold_ack_o (hold_ack_o),
      .gnt_o      (gnt_o),
      .core_hold_o(core_hold_o)
   );

   // R1
   reset_idle_chk: assert property (@(posedge clk) disable iff (1'b0)
      qual_rst |=> (!core_hold_o && !hold_ack_o && (gnt_o == '0)));

   // R8
   one_owner_chk: assert property (@(posedge clk) disable iff (rst_i)
      $onehot0({hold_ack_o, gnt_o}));

   // R2
   hold_core_chk: assert property (@(posedge clk) disable iff (rst_i)
      ((|gnt_o) || hold_ack_o) |-> core_hold_o);

   // R3
   boundary_chk: assert property (@(posedge clk) disable iff (rst_i)
      ($rose(|gnt_o) || $rose(hold_ack_o)) |-> $past(cyc_end_i));

   // R4
   lock_chk: assert property (@(posedge clk) disable iff (rst_i)
      ($rose(|gnt_o) || $rose(hold_ack_o)) |-> $past(lock_n_i));

   // R5
   prio_chk: assert property (@(posedge clk) disable iff (rst_i)
      (core_hold_o && !(|gnt_o) && !hold_ack_o && cyc_end_i && lock_n_i && req_i[0])
      |=> gnt_o[0]);

   // R6
   release_chk: assert property (@(posedge clk) disable iff (rst_i)
      (|(gnt_o & (~req_i | rel_i))) |=> ((gnt_o == '0) && !core_hold_o));

   // R9
   hold_ack_chk: assert property (@(posedge clk) disable iff (rst_i)
      $rose(hold_ack_o) |-> $past(hold_req_i));

endmodule

// File: tb/tb_bus_master_arbiter.sv
module tb_bus_master_arbiter;
   logic       clk = 1'b0;
   logic       rst_i = 1'b1;
   logic       hold_req_i = 1'b0;
   logic       hold_ack_o;
   logic [1:0] req_i = 2'b00;
   logic [1:0] rel_i = 2'b00;
   logic [1:0] gnt_o;
   logic       cyc_end_i = 1'b0;
   logic       lock_n_i = 1'b1;
   logic       core_hold_o;

   int    checks = 0;
   int    fails  = 0;
   bit    active = 1'b0;
   bit    done   = 1'b0;
   string tag    = "R1";

   // Reference model: 0 core, 1 waiting, 2 hold, 3 channel 0, 4 channel 1
   int ms = 0;
   int rc = 0;

   always #5 clk = ~clk;

   bus_master_arbiter dut (
      .clk(clk), .rst_i(rst_i), .hold_req_i(hold_req_i), .hold_ack_o(hold_ack_o),
      .req_i(req_i), .rel_i(rel_i), .gnt_o(gnt_o), .cyc_end_i(cyc_end_i),
      .lock_n_i(lock_n_i), .core_hold_o(core_hold_o)
   );

   always @(posedge clk) begin
      int win;
      bit any;
      rc  = rst_i ? rc + 1 : 0;
      any = hold_req_i || (req_i != 2'b00);
      win = req_i[0] ? 3 : (req_i[1] ? 4 : 2);
      if (rst_i && rc >= 4) ms = 0;
      else begin
         case (ms)
            0: if (any) ms = 1;
            1: if (!any) ms = 0; else if (cyc_end_i && lock_n_i) ms = win;
            2: if (!hold_req_i) ms = 0;
            3: if (!req_i[0] || rel_i[0]) ms = 0;
            4: if (!req_i[1] || rel_i[1]) ms = 0;
            default: ms = 0;
         endcase
      end
   end

   always @(negedge clk) begin
      if (active) begin
         logic [3:0] got, exp;
         got = {hold_ack_o, gnt_o, core_hold_o};
         exp = {ms == 2, ms == 4, ms == 3, ms != 0};
         checks++;
         if (got !== exp) begin
            fails++;
            $display("FAIL %s: {ack,gnt,core_hold} actual %b expected %b", tag, got, exp);
         end
         checks++;
         if ($countones({hold_ack_o, gnt_o}) > 1) begin
            fails++;
            $display("FAIL R8: owners actual %b expected at most one", {hold_ack_o, gnt_o});
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         summary();
         $finish;
      end
   end

   initial begin
      // R1: qualified reset
      step(5);
      rst_i = 1'b0;
      active = 1'b1;
      step(2);

      // R2, R3: channel 1 waits for a boundary
      tag = "R2"; req_i = 2'b10; step(1);
      tag = "R3"; step(3);
      cyc_end_i = 1'b1; step(1); cyc_end_i = 1'b0; step(2);
      // R6: drop request
      tag = "R6"; req_i = 2'b00; step(2);

      // R5: both channels at the same boundary
      tag = "R5"; req_i = 2'b11; step(1);
      cyc_end_i = 1'b1; step(1); cyc_end_i = 1'b0; step(2);
      // R7: channel 0 releases by pulse, channel 1 still asking
      tag = "R7"; rel_i = 2'b01; req_i = 2'b10; step(1); rel_i = 2'b00;
      cyc_end_i = 1'b1; step(4); cyc_end_i = 1'b0;
      // R6: release pulse on channel 1
      tag = "R6"; rel_i = 2'b10; step(1); rel_i = 2'b00; req_i = 2'b00; step(2);

      // R4: locked sequence holds off, lock clears on a boundary
      tag = "R4"; lock_n_i = 1'b0; req_i = 2'b01; cyc_end_i = 1'b1; step(4);
      lock_n_i = 1'b1; step(1); cyc_end_i = 1'b0; step(2);
      req_i = 2'b00; step(2);

      // R9: hold request acknowledged, then withdrawn while waiting
      tag = "R9"; hold_req_i = 1'b1; step(1); cyc_end_i = 1'b1; step(1);
      cyc_end_i = 1'b0; step(2); hold_req_i = 1'b0; step(2);
      hold_req_i = 1'b1; step(2); hold_req_i = 1'b0; step(2);
      // R5: channel beats hold
      tag = "R5"; hold_req_i = 1'b1; req_i = 2'b10; step(1);
      cyc_end_i = 1'b1; step(1); cyc_end_i = 1'b0; step(1);

      // R1: short reset pulse has no effect, full one clears
      tag = "R1"; rst_i = 1'b1; step(3); rst_i = 1'b0; step(2);
      rst_i = 1'b1; step(4); rst_i = 1'b0; step(1);
      hold_req_i = 1'b0; req_i = 2'b00; step(2);

      // R8: random stress
      tag = "R8";
      for (int k = 0; k < 4000; k++) begin
         req_i      = 2'($urandom_range(0, 3));
         hold_req_i = ($urandom_range(0, 3) == 0);
         rel_i      = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
         cyc_end_i  = ($urandom_range(0, 2) == 0);
         lock_n_i   = ($urandom_range(0, 4) != 0);
         rst_i      = ($urandom_range(0, 40) == 0) ? 1'b1 : (rst_i && $urandom_range(0, 5) != 0);
         step(1);
      end
      rst_i = 1'b0; req_i = 2'b00; hold_req_i = 1'b0; rel_i = 2'b00;
      step(3);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule